// File: doc/BRIEF.md
# Channel and Die Select Dehasher

This block undoes the XOR hash that a memory interleaver applies to the channel-select and die-select bits of a physical address. Software or a fabric error-handling path presents a hashed 64-bit address together with the interleave configuration: channel count, die count, interleave start position, socket count and five hash-granularity enables. The block returns the address with every hashed select bit restored to its original value.

The correction runs one select bit per clock. Channel select bits are fixed first, in ascending order, and die select bits follow. Each step reads the address as the earlier steps left it. The channel select bits are not contiguous: the first four sit at bits 8 to 11 and the fifth sits at bit 14. The 4K enable reaches only the lowest three channel bits, and the 1T enable gates two separate address terms for each channel bit. A configuration that is not supported is rejected at once with an error flag.

Top module: `chdie_dehash`

## Requirements
- R1: A start that is accepted while the interleave position is not 8, the die count is above 4 or the socket count is above 1 sets `err` and raises `done` one cycle later, and `addr_out` equals `addr_in` unchanged.
- R2: A channel count that is zero, not a power of two or above 32, or a die count that is zero or not a power of two, is rejected in the same way as R1.
- R3: The number of channel steps is log2 of the channel count. Channel step i targets address bit 8+i, except step 4, which targets bit 14.
- R4: The 4K enable (`hash_en` bit 0) adds address bit 12+i to channel steps 0, 1 and 2 only.
- R5: Every channel step i also XORs bit 15+i when 64K (`hash_en` bit 1) is set, bit 22+i when 2M (bit 2) is set, bit 29+i when 1G (bit 3) is set, and both bits 36+i and 43+i when 1T (bit 4) is set.
- R6: There are log2(die count) die steps. Die step i targets bit 12+i and XORs bit 20+i (64K), 27+i (2M), 34+i (1G) and 41+i (1T).
- R7: All channel steps run before any die step, each group in ascending order, and every step sees the address as already corrected by the earlier steps.
- R8: A target bit is inverted only when the XOR of its enabled hash terms is 1. No address bit other than 8 to 14 ever changes.
- R9: When a valid start is accepted on a clock edge, `done` is high for exactly one cycle after N further edges, where N is the total number of channel and die steps (after that same edge when N is 0). `addr_out` changes by at most one bit per cycle.
- R10: A start that arrives while a correction is in progress is ignored. The result and its timing are those of the first request.
- R11: After reset, `addr_out` is zero and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; sampled while idle |
| addr_in | input | 64 | Hashed address |
| chan_cnt | input | 7 | Number of interleaved channels |
| die_cnt | input | 3 | Number of interleaved dies |
| intlv_pos | input | 6 | Interleave start bit position |
| sock_cnt | input | 3 | Number of interleaved sockets |
| hash_en | input | 5 | Hash enables: bit0 4K, bit1 64K, bit2 2M, bit3 1G, bit4 1T |
| addr_out | output | 64 | Corrected address, valid when done is high |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Configuration rejected; valid with done |

## Verification
The bench sweeps every supported channel and die count against all 32 enable combinations. It compares each result with a sequential model built from the requirements. A design that applied the 4K term to channel step 3, placed the fifth channel bit at 12 instead of 14, used only one of the two 1T terms, or ran die steps before channel steps would produce a wrong bit somewhere in this sweep. Targeted cases check the bit-14 collision between the 4K term of channel step 2 and the target of step 4, and also each rejection condition and the exact completion latency. A second start during a long run is also checked, because a design that accepted it would return the second address or shift the timing of `done`.

// File: rtl/dh_pkg.sv
package dh_pkg;
    localparam int ADDR_W      = 64;
    localparam int CH_CNT_W    = 7;
    localparam int DIE_CNT_W   = 3;
    localparam int SOCK_CNT_W  = 3;
    localparam int POS_W       = 6;
    localparam int CH_MAX_BITS = 5;
    localparam int DIE_MAX_BITS = 2;
    localparam int NCH_W       = $clog2(CH_MAX_BITS + 1);
    localparam int NDIE_W      = $clog2(DIE_MAX_BITS + 1);
    localparam int STEP_W      = $clog2(CH_MAX_BITS + DIE_MAX_BITS + 1);
    localparam int IDX_W       = $clog2(ADDR_W);

    localparam int REQ_POS     = 8;
    localparam int DIE_LIMIT   = 4;
    localparam int SOCK_LIMIT  = 1;

    localparam int CH_BASE     = 8;
    localparam int CH_JUMP_IDX = 4;
    localparam int CH_JUMP_BIT = 14;
    localparam int CH_4K_LAST  = 2;
    localparam int CH_4K       = 12;
    localparam int CH_64K      = 15;
    localparam int CH_2M       = 22;
    localparam int CH_1G       = 29;
    localparam int CH_1TA      = 36;
    localparam int CH_1TB      = 43;
    localparam int DIE_BASE    = 12;
    localparam int DIE_64K     = 20;
    localparam int DIE_2M      = 27;
    localparam int DIE_1G      = 34;
    localparam int DIE_1T      = 41;

    localparam logic [ADDR_W-1:0] TGT_MASK = ADDR_W'(64'h7F00);

    typedef struct packed {
        logic t1t;
        logic g1;
        logic m2;
        logic k64;
        logic k4;
    } hash_en_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} dh_state_e;

    typedef struct packed {
        dh_state_e          st;
        logic [ADDR_W-1:0]  addr;
        logic [STEP_W-1:0]  step;
        logic [STEP_W-1:0]  last;
        logic [NCH_W-1:0]   nch;
        hash_en_t           en;
        logic               done;
        logic               err;
    } dh_regs_t;
endpackage

// File: rtl/dh_validate.sv
module dh_validate
    import dh_pkg::*;
(
    input  logic [CH_CNT_W-1:0]   chan_cnt,
    input  logic [DIE_CNT_W-1:0]  die_cnt,
    input  logic [POS_W-1:0]      intlv_pos,
    input  logic [SOCK_CNT_W-1:0] sock_cnt,
    output logic                  bad,
    output logic [NCH_W-1:0]      nch,
    output logic [NDIE_W-1:0]     ndie
);
    logic ch_pow2, die_pow2;

    always_comb begin
        ch_pow2  = (chan_cnt != '0) && ((chan_cnt & (chan_cnt - 1'b1)) == '0);
        die_pow2 = (die_cnt  != '0) && ((die_cnt  & (die_cnt  - 1'b1)) == '0);
        nch  = '0;
        ndie = '0;
        for (int k = 0; k <= CH_MAX_BITS; k++) begin
            if (chan_cnt[k]) nch = NCH_W'(k);
        end
        for (int k = 0; k <= DIE_MAX_BITS; k++) begin
            if (die_cnt[k]) ndie = NDIE_W'(k);
        end
        bad = (intlv_pos != POS_W'(REQ_POS))
            || (die_cnt > DIE_CNT_W'(DIE_LIMIT))
            || (sock_cnt > SOCK_CNT_W'(SOCK_LIMIT))
            || (chan_cnt > CH_CNT_W'(1 << CH_MAX_BITS))
            || !ch_pow2 || !die_pow2;
    end
endmodule

// File: rtl/dh_step_hash.sv
module dh_step_hash
    import dh_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [STEP_W-1:0] step,
    input  logic [NCH_W-1:0]  nch,
    input  hash_en_t          en,
    output logic [IDX_W-1:0]  tgt,
    output logic              flip
);
    function automatic logic bit_at(input logic [ADDR_W-1:0] a, input int pos);
        return a[pos[IDX_W-1:0]];
    endfunction

    int   idx;
    logic is_die;

    always_comb begin
        is_die = step >= STEP_W'(nch);
        flip   = 1'b0;
        if (!is_die) begin
            idx = int'(step);
            tgt = (idx == CH_JUMP_IDX) ? IDX_W'(CH_JUMP_BIT) : IDX_W'(CH_BASE + idx);
            if (en.k4 && idx <= CH_4K_LAST) flip ^= bit_at(addr, CH_4K + idx);
            if (en.k64) flip ^= bit_at(addr, CH_64K + idx);
            if (en.m2)  flip ^= bit_at(addr, CH_2M + idx);
            if (en.g1)  flip ^= bit_at(addr, CH_1G + idx);
            if (en.t1t) flip ^= bit_at(addr, CH_1TA + idx) ^ bit_at(addr, CH_1TB + idx);
        end else begin
            idx = int'(step) - int'(nch);
            tgt = IDX_W'(DIE_BASE + idx);
            if (en.k64) flip ^= bit_at(addr, DIE_64K + idx);
            if (en.m2)  flip ^= bit_at(addr, DIE_2M + idx);
            if (en.g1)  flip ^= bit_at(addr, DIE_1G + idx);
            if (en.t1t) flip ^= bit_at(addr, DIE_1T + idx);
        end
    end
endmodule

// File: rtl/chdie_dehash.sv
module chdie_dehash
    import dh_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic [CH_CNT_W-1:0]   chan_cnt,
    input  logic [DIE_CNT_W-1:0]  die_cnt,
    input  logic [POS_W-1:0]      intlv_pos,
    input  logic [SOCK_CNT_W-1:0] sock_cnt,
    input  logic [4:0]            hash_en,
    output logic [ADDR_W-1:0]     addr_out,
    output logic                  done,
    output logic                  err
);
    dh_regs_t          q, d;
    logic              cfg_bad;
    logic [NCH_W-1:0]  cfg_nch;
    logic [NDIE_W-1:0] cfg_ndie;
    logic [STEP_W-1:0] cfg_total;
    logic [IDX_W-1:0]  step_tgt;
    logic              step_flip;

    dh_validate u_validate (
        .chan_cnt  (chan_cnt),
        .die_cnt   (die_cnt),
        .intlv_pos (intlv_pos),
        .sock_cnt  (sock_cnt),
        .bad       (cfg_bad),
        .nch       (cfg_nch),
        .ndie      (cfg_ndie)
    );

    dh_step_hash u_step (
        .addr (q.addr),
        .step (q.step),
        .nch  (q.nch),
        .en   (q.en),
        .tgt  (step_tgt),
        .flip (step_flip)
    );

    assign cfg_total = STEP_W'(cfg_nch) + STEP_W'(cfg_ndie);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.addr = addr_in;
                    d.nch  = cfg_nch;
                    d.en   = hash_en_t'(hash_en);
                    d.step = '0;
                    d.last = cfg_total - 1'b1;
                    if (cfg_bad) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else if (cfg_total == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                d.addr = q.addr ^ (ADDR_W'(step_flip) << step_tgt);
                d.step = q.step + 1'b1;
                if (q.step == q.last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_out = q.addr;
    assign done     = q.done;
    assign err      = q.err;

    assert_err_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_reject_bad_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start && cfg_bad) |=> (done && err && addr_out == $past(addr_in)));

    assert_one_bit_per_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |=> ($countones(addr_out ^ $past(addr_out)) <= 1));

    assert_only_select_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |=> (((addr_out ^ $past(addr_out)) & ~TGT_MASK) == '0));

    assert_done_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.step != q.last) |=> (q.st == ST_RUN && $stable(q.en) && $stable(q.nch) && $stable(q.last)));
endmodule

// File: tb/test_chdie_dehash.sv
`timescale 1ns/1ps
module test_chdie_dehash;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] addr_in = '0;
    logic [6:0]  chan_cnt = 7'd8;
    logic [2:0]  die_cnt = 3'd1;
    logic [5:0]  intlv_pos = 6'd8;
    logic [2:0]  sock_cnt = 3'd1;
    logic [4:0]  hash_en = '0;
    logic [63:0] addr_out;
    logic        done, err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    chdie_dehash i_chdie_dehash (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
        .chan_cnt(chan_cnt), .die_cnt(die_cnt), .intlv_pos(intlv_pos),
        .sock_cnt(sock_cnt), .hash_en(hash_en),
        .addr_out(addr_out), .done(done), .err(err)
    );

    function automatic logic [63:0] model(input logic [63:0] a, input int nc,
                                          input int nd, input logic [4:0] en);
        logic p;
        int   t;
        for (int i = 0; i < nc; i++) begin
            t = (i == 4) ? 14 : 8 + i;
            p = 1'b0;
            if (en[0] && i < 3) p ^= a[12 + i];
            if (en[1]) p ^= a[15 + i];
            if (en[2]) p ^= a[22 + i];
            if (en[3]) p ^= a[29 + i];
            if (en[4]) p ^= a[36 + i] ^ a[43 + i];
            if (p) a[t] = ~a[t];
        end
        for (int i = 0; i < nd; i++) begin
            p = 1'b0;
            if (en[1]) p ^= a[20 + i];
            if (en[2]) p ^= a[27 + i];
            if (en[3]) p ^= a[34 + i];
            if (en[4]) p ^= a[41 + i];
            if (p) a[12 + i] = ~a[12 + i];
        end
        return a;
    endfunction

    function automatic int lg(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] a, input int ch, input int dc,
                       input int pos, input int sc, input logic [4:0] en, input bit bad);
        int cyc;
        int steps;
        addr_in = a; chan_cnt = 7'(ch); die_cnt = 3'(dc);
        intlv_pos = 6'(pos); sock_cnt = 3'(sc); hash_en = en;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        steps = bad ? 0 : lg(ch) + lg(dc);
        check({tag, " R9 latency"}, 64'(cyc), 64'(steps + 1));
        check({tag, " R1 R2 err"}, 64'(err), 64'(bad));
        check({tag, " result"}, addr_out, bad ? a : model(a, lg(ch), lg(dc), en));
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] a;
        int cyc;
        repeat (3) @(negedge clk);
        check("R11 reset addr", addr_out, 64'h0);
        check("R11 reset done", 64'(done), 64'h0);
        check("R11 reset err", 64'(err), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 rejection conditions
        run("R1 pos9",   64'h1234_5678_9ABC_DEF0, 8, 1, 9, 1, 5'h1F, 1'b1);
        run("R1 die8",   64'h1111_2222_3333_4444, 8, 8, 8, 1, 5'h1F, 1'b1);
        run("R1 sock2",  64'hFFFF_0000_FFFF_0000, 16, 2, 8, 2, 5'h1F, 1'b1);
        // R2 non power-of-two and out of range counts
        run("R2 ch12",   64'hDEAD_BEEF_0000_7F00, 12, 1, 8, 1, 5'h1F, 1'b1);
        run("R2 ch0",    64'hDEAD_BEEF_0000_7F00, 0, 1, 8, 1, 5'h1F, 1'b1);
        run("R2 ch64",   64'hDEAD_BEEF_0000_7F00, 64, 1, 8, 1, 5'h1F, 1'b1);
        run("R2 die3",   64'hDEAD_BEEF_0000_7F00, 8, 3, 8, 1, 5'h1F, 1'b1);
        run("R2 die0",   64'hDEAD_BEEF_0000_7F00, 8, 0, 8, 1, 5'h1F, 1'b1);

        // R4: bit 12 with 4K only flips bit 8; bit 15 with 4K only (step 3) changes nothing
        run("R4 ch0 4K", 64'h0000_0000_0000_1000, 8, 1, 8, 1, 5'h01, 1'b0);
        check("R4 bit8 flipped", addr_out, 64'h0000_0000_0000_1100);
        run("R4 ch3 no4K", 64'h0000_0000_0000_8000, 16, 1, 8, 1, 5'h01, 1'b0);
        check("R4 step3 untouched", addr_out, 64'h0000_0000_0000_8000);
        // R3: fifth channel step targets bit 14 (1G term bit 33)
        run("R3 jump14", 64'h0000_0002_0000_0000, 32, 1, 8, 1, 5'h08, 1'b0);
        check("R3 bit14 flipped", addr_out, 64'h0000_0002_0000_4000);
        // R5: both 1T terms of step 0 cancel
        run("R5 1T pair", 64'h0000_0810_0000_0000, 8, 1, 8, 1, 5'h10, 1'b0);
        check("R5 1T cancel", addr_out, 64'h0000_0810_0000_0000);
        // R6: die step 1 from 2M term bit 28 flips bit 13
        run("R6 die1", 64'h0000_0000_1000_0000, 1, 4, 8, 1, 5'h04, 1'b0);
        check("R6 bit13 flipped", addr_out, 64'h0000_0000_1000_2000);
        // R7: step 2 4K term reads bit 14 before step 4 rewrites it
        run("R7 order", 64'h0000_0002_0000_0000, 32, 1, 8, 1, 5'h09, 1'b0);
        check("R7 seq result", addr_out, 64'h0000_0002_0000_4000);

        // R3 R5 R6 R7 R8 sweep
        for (int ci = 0; ci <= 5; ci++) begin
            for (int di = 0; di <= 2; di++) begin
                for (int e = 0; e < 32; e++) begin
                    for (int r = 0; r < 2; r++) begin
                        a = {$urandom, $urandom};
                        run("R3 R5 R6 R7 R8 sweep", a, 1 << ci, 1 << di, 8, r, 5'(e), 1'b0);
                    end
                end
            end
        end

        // R10: second start during a 7-step run is ignored
        a = 64'hA5A5_5A5A_C3C3_3C3C;
        addr_in = a; chan_cnt = 7'd32; die_cnt = 3'd4; intlv_pos = 6'd8;
        sock_cnt = 3'd1; hash_en = 5'h1F;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        addr_in = 64'h0; chan_cnt = 7'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 3;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check("R10 latency", 64'(cyc), 64'd8);
        check("R10 err", 64'(err), 64'h0);
        check("R10 result", addr_out, model(a, 5, 2, 5'h1F));
        @(negedge clk);
        check("R10 no second done", 64'(done), 64'h0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule